// File: doc/BRIEF.md
# Word Multiply Unit with Overflow Reporting

This block is the multiply stage of a 64-bit fixed-point execution pipeline. It handles four multiply flavours. One multiplies a full 64-bit register by a sign-extended 16-bit immediate. The other three are word forms that look only at the low 32 bits of each register operand: a signed low-word product, a signed high word and an unsigned high word. A request is accepted on any cycle where `in_valid` is high. The answer comes back one clock later, together with everything the pipeline needs to update architectural state.

That state update has three parts. The first is the 64-bit destination value. The second is a write strobe for the overflow pair (full overflow and 32-bit overflow), plus a pulse that sets the sticky summary-overflow bit held elsewhere. The third is a condition-field write, used when the instruction is a record form. The condition field always comes from a signed 64-bit comparison of the written value against zero.

Top module: `wmul_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high; a new request may be issued every cycle.
- R2: Operation code 2'b00 (immediate multiply) returns the low 64 bits of the signed product of the full 64-bit `in_a` and the sign-extended 16-bit `in_imm`.
- R3: Operation code 2'b01 (low word) returns the full 64-bit signed product of `in_a[31:0]` and `in_b[31:0]`, both taken as signed.
- R4: For operation 2'b01, `out_ov_we` is 1. `out_ov` and `out_ov32` are both 1 when the product differs from the sign extension of its own bits 31..0, and are both 0 otherwise.
- R5: `out_so_set` is 1 exactly when R4 reports an overflow, and is 0 in every other case.
- R6: Operation code 2'b10 (signed high word) returns bits 63..32 of the signed product of the two low words in result bits 31..0, with result bits 63..32 zero.
- R7: Operation code 2'b11 (unsigned high word) returns bits 63..32 of the unsigned product of the two low words in result bits 31..0, with result bits 63..32 zero.
- R8: Operations other than 2'b01 leave the overflow state untouched: `out_ov_we`, `out_ov`, `out_ov32` and `out_so_set` are all 0.
- R9: For operations 2'b01, 2'b10 and 2'b11, `out_cr_we` equals the `in_rec` of the request. `out_cr` is a one-hot code from the signed 64-bit compare of the result with zero: bit 2 means less than, bit 1 means greater than, bit 0 means equal.
- R10: Operation 2'b00 has no record form: `in_rec` has no effect, and `out_cr_we` is 0.
- R11: While `rst` is high at a clock edge, every output is cleared to zero on that edge.
- R12: For operations 2'b01, 2'b10 and 2'b11, bits 63..32 of `in_a` and `in_b` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 2 | Operation code (see R2, R3, R6, R7) |
| in_rec | input | 1 | Record form: request a condition-field write |
| in_a | input | 64 | First register operand |
| in_b | input | 64 | Second register operand |
| in_imm | input | 16 | Immediate for operation 2'b00 |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 64 | Destination value |
| out_ov_we | output | 1 | Overflow pair write strobe |
| out_ov | output | 1 | Overflow flag value |
| out_ov32 | output | 1 | 32-bit overflow flag value |
| out_so_set | output | 1 | Set the sticky summary-overflow bit |
| out_cr_we | output | 1 | Condition-field write strobe |
| out_cr | output | 3 | Condition code {lt, gt, eq} |

## Verification
The embedded assertions rely on two assumptions. The first is that `in_op` is a settled, known value in every cycle where `in_valid` is high. The second is that `rst` is held for at least one edge before the first request, so that the `$past` sampling of the op code never reaches back into pre-reset garbage. The bench meets both. It drives every input on the falling edge and keeps `in_valid` low during reset. It draws operation codes only from the four defined values. Operands get random upper halves, which exercises the word forms' disregard of bits 63..32. Directed cases add the extreme operand pairs, where overflow appears or vanishes.

// File: rtl/wmul_pkg.sv
package wmul_pkg;

    localparam int XLEN = 64;
    localparam int WLEN = 32;
    localparam int IMMW = 16;

    typedef enum logic [1:0] {
        OP_MULI   = 2'b00,
        OP_MULLW  = 2'b01,
        OP_MULHW  = 2'b10,
        OP_MULHWU = 2'b11
    } mul_op_e;

    typedef struct packed {
        logic            ov_we;
        logic            ov;
        logic            ov32;
        logic            so_set;
        logic            cr_we;
        logic [2:0]      cr;
    } mul_flags_t;

    typedef struct packed {
        logic [XLEN-1:0] value;
        mul_flags_t      flags;
    } mul_out_t;

    // Condition code {lt, gt, eq} from a signed compare with zero
    function automatic logic [2:0] sign_code(input logic [XLEN-1:0] v);
        logic lt;
        logic eq;
        lt = v[XLEN-1];
        eq = (v == '0);
        return {lt, !lt && !eq, eq};
    endfunction

    function automatic logic [XLEN-1:0] sext_word(input logic [WLEN-1:0] w);
        return {{(XLEN-WLEN){w[WLEN-1]}}, w};
    endfunction

    function automatic logic [XLEN-1:0] zext_word(input logic [WLEN-1:0] w);
        return {{(XLEN-WLEN){1'b0}}, w};
    endfunction

endpackage

// File: rtl/wmul_datapath.sv
module wmul_datapath
    import wmul_pkg::*;
(
    input  mul_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [IMMW-1:0] imm,
    output logic [XLEN-1:0] value,
    output logic [XLEN-1:0] word_prod
);

    logic signed [XLEN-1:0] imm_ext;
    logic signed [XLEN-1:0] a_full;
    logic signed [XLEN-1:0] a_ws;
    logic signed [XLEN-1:0] b_ws;
    logic signed [XLEN-1:0] prod_imm;
    logic signed [XLEN-1:0] prod_s;
    logic        [XLEN-1:0] prod_u;
    logic        [WLEN-1:0] unused_b_hi;

    assign unused_b_hi = b[XLEN-1:WLEN];

    always_comb begin
        imm_ext  = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
        a_full   = a;
        a_ws     = sext_word(a[WLEN-1:0]);
        b_ws     = sext_word(b[WLEN-1:0]);
        prod_imm = a_full * imm_ext;
        prod_s   = a_ws * b_ws;
        prod_u   = zext_word(a[WLEN-1:0]) * zext_word(b[WLEN-1:0]);
    end

    always_comb begin
        unique case (op)
            OP_MULI:   value = prod_imm;
            OP_MULLW:  value = prod_s;
            OP_MULHW:  value = zext_word(prod_s[XLEN-1:WLEN]);
            OP_MULHWU: value = zext_word(prod_u[XLEN-1:WLEN]);
            default:   value = '0;
        endcase
    end

    assign word_prod = prod_s;

endmodule

// File: rtl/wmul_status.sv
module wmul_status
    import wmul_pkg::*;
(
    input  mul_op_e         op,
    input  logic            rec,
    input  logic [XLEN-1:0] value,
    input  logic [XLEN-1:0] word_prod,
    output mul_flags_t      flags
);

    logic no_fit;

    // Product does not survive truncation to a signed word
    assign no_fit = (word_prod != sext_word(word_prod[WLEN-1:0]));

    always_comb begin
        flags = '0;
        if (op == OP_MULLW) begin
            flags.ov_we  = 1'b1;
            flags.ov     = no_fit;
            flags.ov32   = no_fit;
            flags.so_set = no_fit;
        end
        if (op != OP_MULI) begin
            flags.cr_we = rec;
        end
        flags.cr = flags.cr_we ? sign_code(value) : 3'b000;
    end

endmodule

// File: rtl/wmul_unit.sv
module wmul_unit
    import wmul_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [1:0]      in_op,
    input  logic            in_rec,
    input  logic [63:0]     in_a,
    input  logic [63:0]     in_b,
    input  logic [15:0]     in_imm,
    output logic            out_valid,
    output logic [63:0]     out_result,
    output logic            out_ov_we,
    output logic            out_ov,
    output logic            out_ov32,
    output logic            out_so_set,
    output logic            out_cr_we,
    output logic [2:0]      out_cr
);

    mul_op_e         op;
    logic [XLEN-1:0] value;
    logic [XLEN-1:0] word_prod;
    mul_flags_t      flags;
    mul_out_t        stage_q;
    logic            valid_q;

    assign op = mul_op_e'(in_op);

    wmul_datapath u_dp (
        .op        (op),
        .a         (in_a),
        .b         (in_b),
        .imm       (in_imm),
        .value     (value),
        .word_prod (word_prod)
    );

    wmul_status u_st (
        .op        (op),
        .rec       (in_rec),
        .value     (value),
        .word_prod (word_prod),
        .flags     (flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            stage_q <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                stage_q.value <= value;
                stage_q.flags <= flags;
            end else begin
                stage_q <= '0;
            end
        end
    end

    assign out_valid  = valid_q;
    assign out_result = stage_q.value;
    assign out_ov_we  = stage_q.flags.ov_we;
    assign out_ov     = stage_q.flags.ov;
    assign out_ov32   = stage_q.flags.ov32;
    assign out_so_set = stage_q.flags.so_set;
    assign out_cr_we  = stage_q.flags.cr_we;
    assign out_cr     = stage_q.flags.cr;

    // R1: one-cycle latency
    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R4: overflow pair always agrees
    a_r4_ov_pair: assert property (@(posedge clk) disable iff (rst)
        out_ov == out_ov32);

    // R5: summary set only alongside a written overflow
    a_r5_so_follows_ov: assert property (@(posedge clk) disable iff (rst)
        out_so_set |-> (out_ov_we && out_ov));

    // R8: only the low-word op writes overflow state
    a_r8_ov_owner: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op != 2'b01) |=> !out_ov_we && !out_so_set);

    // R6, R7: high-word forms leave the upper half zero
    a_r6_r7_hi_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[1]) |=> (out_result[63:32] == 32'h0));

    // R9: condition code is one-hot when written
    a_r9_cr_onehot: assert property (@(posedge clk) disable iff (rst)
        out_cr_we |-> ($countones(out_cr) == 1));

    // R10: immediate form never writes the condition field
    a_r10_no_rec_imm: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'b00) |=> !out_cr_we);

endmodule

// File: tb/test_wmul_unit.sv
module test_wmul_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic        in_rec = 1'b0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic [15:0] in_imm = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_ov_we, out_ov, out_ov32, out_so_set, out_cr_we;
    logic [2:0]  out_cr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wmul_unit i_wmul_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_rec(in_rec), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
        .out_valid(out_valid), .out_result(out_result),
        .out_ov_we(out_ov_we), .out_ov(out_ov), .out_ov32(out_ov32),
        .out_so_set(out_so_set), .out_cr_we(out_cr_we), .out_cr(out_cr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_value(input logic [1:0] op, input logic [63:0] a,
                                                input logic [63:0] b, input logic [15:0] imm);
        longint          s;
        longint unsigned u;
        case (op)
            2'b00: begin s = longint'(a) * longint'(shortint'(imm)); return s; end
            2'b01: begin s = longint'(int'(a[31:0])) * longint'(int'(b[31:0])); return s; end
            2'b10: begin s = longint'(int'(a[31:0])) * longint'(int'(b[31:0]));
                         return {32'h0, s[63:32]}; end
            default: begin u = longint'({32'h0, a[31:0]}) * longint'({32'h0, b[31:0]});
                         return {32'h0, u[63:32]}; end
        endcase
    endfunction

    function automatic logic model_ovf(input logic [63:0] a, input logic [63:0] b);
        longint s;
        s = longint'(int'(a[31:0])) * longint'(int'(b[31:0]));
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    task automatic issue(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic [15:0] imm, input logic rec);
        logic [63:0] ev;
        logic        ov;
        logic        crw;
        logic [2:0]  cr;
        ev  = model_value(op, a, b, imm);
        ov  = (op == 2'b01) && model_ovf(a, b);
        crw = rec && (op != 2'b00);
        cr  = !crw ? 3'b000 : ($signed(ev) < 0) ? 3'b100 : (ev == 0) ? 3'b001 : 3'b010;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_imm = imm; in_rec = rec;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 valid", 64'(out_valid), 64'd1);
        case (op)
            2'b00: check("R2 imm product", out_result, ev);
            2'b01: check("R3 low word / R12", out_result, ev);
            2'b10: check("R6 signed high / R12", out_result, ev);
            default: check("R7 unsigned high / R12", out_result, ev);
        endcase
        if (op == 2'b01) begin
            check("R4 ov_we", 64'(out_ov_we), 64'd1);
            check("R4 ov", 64'(out_ov), 64'(ov));
            check("R4 ov32", 64'(out_ov32), 64'(ov));
            check("R5 so_set", 64'(out_so_set), 64'(ov));
        end else begin
            check("R8 no ov write", {60'h0, out_ov_we, out_ov, out_ov32, out_so_set}, 64'h0);
        end
        if (op == 2'b00) check("R10 no cr write", 64'(out_cr_we), 64'd0);
        else             check("R9 cr_we", 64'(out_cr_we), 64'(crw));
        if (crw)         check("R9 cr code", 64'(out_cr), 64'(cr));
    endtask

    initial begin : watchdog
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check("R11 reset outputs", {out_valid, out_ov_we, out_ov, out_ov32, out_so_set,
                                    out_cr_we, out_cr, 54'h0} | {10'h0, out_result[53:0]}, 64'h0);
        check("R11 reset result", out_result, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle", 64'(out_valid), 64'd0);

        // Directed corners
        issue(2'b01, 64'hFFFF_FFFF_8000_0000, 64'hDEAD_0000_FFFF_FFFF, 16'h0, 1'b1); // overflow
        issue(2'b01, 64'h0000_0000_0000_FFFF, 64'h1234_5678_0000_8000, 16'h0, 1'b1); // fits
        issue(2'b01, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_8000, 16'h0, 1'b1); // just overflows
        issue(2'b01, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0, 1'b1);                    // zero -> eq
        issue(2'b10, 64'hAAAA_AAAA_8000_0000, 64'h5555_5555_8000_0000, 16'h0, 1'b1);
        issue(2'b11, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0, 1'b1);
        issue(2'b10, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 16'h0, 1'b1); // -1 high
        issue(2'b00, 64'h8000_0000_0000_0000, 64'h0, 16'hFFFF, 1'b1);                 // rec ignored
        issue(2'b00, 64'h0000_0001_0000_0000, 64'h0, 16'h7FFF, 1'b0);
        // R12: same low words, different upper halves give the same result
        issue(2'b01, 64'h1111_1111_0000_1234, 64'h2222_2222_FFFF_0003, 16'h0, 1'b0);
        issue(2'b01, 64'h9999_9999_0000_1234, 64'h7777_7777_FFFF_0003, 16'h0, 1'b0);

        // Back-to-back issue
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'b11; in_a = 64'd7; in_b = 64'd9;
        @(negedge clk);
        in_op = 2'b01; in_a = 64'd3; in_b = 64'hFFFF_FFFF_FFFF_FFFE; in_rec = 1'b1;
        check("R1 back-to-back first", out_result, 64'h0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 back-to-back second", out_result, 64'hFFFF_FFFF_FFFF_FFFA);
        check("R9 back-to-back cr", 64'(out_cr), 64'd4);
        @(negedge clk);
        check("R1 valid drops", 64'(out_valid), 64'd0);

        // Random stimulus
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  op;
            logic [63:0] a;
            logic [63:0] b;
            op = 2'($urandom_range(0, 3));
            a  = {$urandom, $urandom};
            b  = {$urandom, $urandom};
            if (i % 4 == 1) a[31:0] = 32'($urandom_range(0, 70000));
            issue(op, a, b, 16'($urandom), 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule